// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This unit performs integer multiplication and division for a 64-bit datapath over several clock cycles. A single start strobe hands it two operands, an operation code, a width choice (32-bit or 64-bit) and a signed/unsigned flag. The operands are captured on the accepting edge, so the caller may change them afterwards. Results land in a pair of 64-bit result registers, `hi` and `lo`, which keep their value between operations. Multiply-accumulate and multiply-subtract therefore build on whatever the previous operation left in them.

The multiplier handles eight multiplier bits per cycle. The divider is a restoring divider that retires one quotient bit per cycle. Signed work is done on magnitudes. The product sign and the quotient sign are the XOR of the operand signs, and the remainder takes the sign of the dividend.

The controller is a state machine with five states:
- `ST_IDLE`: waiting for a start strobe.
- `ST_MUL`: the multiply iterations.
- `ST_DIV`: the divide iterations.
- `ST_FIX`: sign correction of the quotient and remainder.
- `ST_DONE`: a one-cycle completion state.

Its transitions are:
- idle→mul on a start with any code other than divide.
- idle→div on a start with the divide code.
- mul→done after the last multiply step.
- div→fix after the last divide step.
- fix→done.
- done→idle.

Top module: `muldiv_iter`

## Requirements
- R1: While reset is asserted and after it is released, before any start: `busy` = 0, `done` = 0, `hi` = 0 and `lo` = 0.
- R2: Multiply operations (codes 0–3) timing:
  - If the start is sampled in cycle 0, `done` is high in cycle 5 for 32-bit width (`wide` = 0) and in cycle 9 for 64-bit width (`wide` = 1).
  - `busy` is high in cycles 1 through the done cycle.
  - `done` lasts one cycle, and `busy` is low in the cycle after it.
- R3: A divide (code 4) raises `done` in cycle 34 for 32-bit width and in cycle 66 for 64-bit width, with the same `busy` behaviour as R2.
- R4: A start strobe is ignored while `busy` is high, including in the done cycle. The running operation keeps its timing and result, and no new operation begins.
- R5: Code 0 (plain multiply) writes the full product.
  - 64-bit width: the 128-bit product, upper half to `hi` and lower half to `lo`.
  - 32-bit width: only operand bits 31:0 are used. `hi` receives product bits 63:32 sign-extended, and `lo` receives bits 31:0 sign-extended.
  - Operands are taken at the accepting edge. Input changes after that edge have no effect.
- R6: Code 1 (three-operand multiply) writes the low product to `lo` (sign-extended in 32-bit width) and leaves `hi` unchanged.
- R7: Code 2 adds the product to, and code 3 subtracts it from, the concatenation {hi,lo}. The concatenation is {hi[31:0],lo[31:0]} at 32-bit width and {hi,lo} at 64-bit width. The result is split back as in R5.
- R8: Code 4 divides `opa` by `opb`.
  - The quotient goes to `lo` and the remainder to `hi`.
  - Signed division truncates toward zero, and the remainder has the sign of the dividend.
  - At 32-bit width both results are sign-extended from bit 31.
  - A quotient that overflows its width wraps.
- R9: A divide by zero raises no error. It completes with the normal divide timing of R3 and leaves `busy` low afterwards.
- R10: `hi` and `lo` change only at the edge that enters the done cycle. In particular, they still hold their previous values in the cycle before `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, sampled only when idle |
| op_sel | input | 3 | 0 multiply, 1 low-product multiply, 2 multiply-add, 3 multiply-subtract, 4 divide |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| is_signed | input | 1 | 1 = two's-complement operands |
| opa | input | 64 | Multiplicand or dividend |
| opb | input | 64 | Multiplier or divisor |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse; results valid from this cycle |
| hi | output | 64 | Upper product half or remainder |
| lo | output | 64 | Lower product half or quotient |

## Verification
Each operation's result is due a fixed number of cycles after the accepting edge: 5 or 9 cycles for multiplies, and 34 or 66 for divides. The bench drives the strobe half a cycle before the edge and samples at every falling edge after it. It counts the cycles until `done` appears and compares that count with the figure for the operation. It reads `hi` and `lo` in that same done cycle, and also one cycle earlier, to confirm they have not yet moved. It then checks `busy` one cycle later, so early, late and stretched completions are all caught.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    // Operation codes seen on op_sel
    typedef enum logic [2:0] {
        OP_MULT = 3'd0,
        OP_MUL3 = 3'd1,
        OP_MADD = 3'd2,
        OP_MSUB = 3'd3,
        OP_DIV  = 3'd4
    } md_op_e;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MUL  = 3'd1,
        ST_DIV  = 3'd2,
        ST_FIX  = 3'd3,
        ST_DONE = 3'd4
    } md_state_e;

endpackage

// File: rtl/muldiv_sign_prep.sv
// Extends an operand to the working width and converts it to a magnitude.
module muldiv_sign_prep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opnd,
    input  logic            wide,
    input  logic            is_signed,
    output logic [XLEN-1:0] mag,
    output logic            neg
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] ext;

    always_comb begin
        if (wide) begin
            ext = opnd;
        end else begin
            ext = {{HALF{is_signed & opnd[HALF-1]}}, opnd[HALF-1:0]};
        end
        neg = is_signed & ext[XLEN-1];
        mag = neg ? (~ext + 1'b1) : ext;
    end
endmodule

// File: rtl/muldiv_mul_step.sv
// One multiply iteration: STEP multiplier bits folded into the accumulator.
module muldiv_mul_step #(
    parameter int XLEN = 64,
    parameter int STEP = 8
) (
    input  logic [2*XLEN-1:0] acc,
    input  logic [2*XLEN-1:0] mcand,
    input  logic [XLEN-1:0]   mplier,
    output logic [2*XLEN-1:0] acc_nx,
    output logic [2*XLEN-1:0] mcand_nx,
    output logic [XLEN-1:0]   mplier_nx
);
    localparam int W2 = 2 * XLEN;

    logic [W2-1:0] pp [STEP];

    for (genvar g = 0; g < STEP; g++) begin : g_pp
        assign pp[g] = mplier[g] ? (mcand << g) : '0;
    end

    always_comb begin
        acc_nx = acc;
        for (int i = 0; i < STEP; i++) begin
            acc_nx = acc_nx + pp[i];
        end
        mcand_nx  = mcand << STEP;
        mplier_nx = mplier >> STEP;
    end
endmodule

// File: rtl/muldiv_div_step.sv
// One restoring-division iteration: one quotient bit.
module muldiv_div_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rem,
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] rem_nx,
    output logic [XLEN-1:0] quo_nx
);
    logic [XLEN:0] trial;
    logic [XLEN:0] diff;

    always_comb begin
        trial = {rem, quo[XLEN-1]};
        diff  = trial - {1'b0, dvs};
        if (!diff[XLEN]) begin
            rem_nx = diff[XLEN-1:0];
            quo_nx = {quo[XLEN-2:0], 1'b1};
        end else begin
            rem_nx = trial[XLEN-1:0];
            quo_nx = {quo[XLEN-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
    import muldiv_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op_sel,
    input  logic            wide,
    input  logic            is_signed,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] lo
);
    localparam int HALF     = XLEN / 2;
    localparam int W2       = 2 * XLEN;
    localparam int MUL_FULL = XLEN / STEP;
    localparam int MUL_HALF = HALF / STEP;
    localparam int CW       = $clog2(XLEN + 1);

    md_state_e       state_q, state_nx;
    logic [2:0]      op_q;
    logic            wide_q, sgn_q, neg_a_q, neg_b_q;
    logic [W2-1:0]   acc_q, mcand_q, acc_nx, mcand_nx;
    logic [XLEN-1:0] mplier_q, mplier_nx;
    logic [XLEN-1:0] rem_q, quo_q, dvs_q, rem_nx, quo_nx;
    logic [CW-1:0]   cnt_q, cnt_init;
    logic [XLEN-1:0] hi_q, lo_q;
    logic [XLEN-1:0] mag_a, mag_b;
    logic            neg_a, neg_b;
    logic            accept, last_iter;

    logic            mul_neg, q_neg, r_neg;
    logic [W2-1:0]   prod_s, cat, mres;
    logic [XLEN-1:0] mul_hi, mul_lo, div_hi, div_lo, qv, rv;

    muldiv_sign_prep #(.XLEN(XLEN)) u_prep_a (
        .opnd(opa), .wide(wide), .is_signed(is_signed), .mag(mag_a), .neg(neg_a)
    );
    muldiv_sign_prep #(.XLEN(XLEN)) u_prep_b (
        .opnd(opb), .wide(wide), .is_signed(is_signed), .mag(mag_b), .neg(neg_b)
    );

    muldiv_mul_step #(.XLEN(XLEN), .STEP(STEP)) u_mul (
        .acc(acc_q), .mcand(mcand_q), .mplier(mplier_q),
        .acc_nx(acc_nx), .mcand_nx(mcand_nx), .mplier_nx(mplier_nx)
    );

    muldiv_div_step #(.XLEN(XLEN)) u_div (
        .rem(rem_q), .quo(quo_q), .dvs(dvs_q), .rem_nx(rem_nx), .quo_nx(quo_nx)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign last_iter = (cnt_q == '0);

    // Iteration count: one less than the number of steps
    always_comb begin
        if (op_sel == OP_DIV) begin
            cnt_init = wide ? CW'(XLEN - 1) : CW'(HALF - 1);
        end else begin
            cnt_init = wide ? CW'(MUL_FULL - 1) : CW'(MUL_HALF - 1);
        end
    end

    // Multiply completion: sign, accumulate, split (R5, R6, R7)
    always_comb begin
        mul_neg = sgn_q & (neg_a_q ^ neg_b_q);
        prod_s  = mul_neg ? (~acc_nx + 1'b1) : acc_nx;
        cat     = wide_q ? {hi_q, lo_q} : {{XLEN{1'b0}}, hi_q[HALF-1:0], lo_q[HALF-1:0]};
        case (op_q)
            OP_MADD: mres = cat + prod_s;
            OP_MSUB: mres = cat - prod_s;
            default: mres = prod_s;
        endcase
        if (wide_q) begin
            mul_hi = mres[W2-1:XLEN];
            mul_lo = mres[XLEN-1:0];
        end else begin
            mul_hi = {{HALF{mres[XLEN-1]}}, mres[XLEN-1:HALF]};
            mul_lo = {{HALF{mres[HALF-1]}}, mres[HALF-1:0]};
        end
        if (op_q == OP_MUL3) begin
            mul_hi = hi_q;
        end
    end

    // Divide completion: quotient and remainder signs (R8)
    always_comb begin
        q_neg = sgn_q & (neg_a_q ^ neg_b_q);
        r_neg = sgn_q & neg_a_q;
        qv    = q_neg ? (~quo_q + 1'b1) : quo_q;
        rv    = r_neg ? (~rem_q + 1'b1) : rem_q;
        if (wide_q) begin
            div_hi = rv;
            div_lo = qv;
        end else begin
            div_hi = {{HALF{rv[HALF-1]}}, rv[HALF-1:0]};
            div_lo = {{HALF{qv[HALF-1]}}, qv[HALF-1:0]};
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_nx = (op_sel == OP_DIV) ? ST_DIV : ST_MUL;
            ST_MUL:  if (last_iter) state_nx = ST_DONE;
            ST_DIV:  if (last_iter) state_nx = ST_FIX;
            ST_FIX:  state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Datapath registers (reset values serve R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            wide_q   <= 1'b0;
            sgn_q    <= 1'b0;
            neg_a_q  <= 1'b0;
            neg_b_q  <= 1'b0;
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
            dvs_q    <= '0;
            cnt_q    <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
        end else begin
            if (accept) begin
                op_q     <= op_sel;
                wide_q   <= wide;
                sgn_q    <= is_signed;
                neg_a_q  <= neg_a;
                neg_b_q  <= neg_b;
                acc_q    <= '0;
                mcand_q  <= {{XLEN{1'b0}}, mag_a};
                mplier_q <= mag_b;
                rem_q    <= '0;
                quo_q    <= wide ? mag_a : (mag_a << HALF);
                dvs_q    <= mag_b;
                cnt_q    <= cnt_init;
            end
            if (state_q == ST_MUL) begin
                acc_q    <= acc_nx;
                mcand_q  <= mcand_nx;
                mplier_q <= mplier_nx;
                cnt_q    <= cnt_q - CW'(1);
                if (last_iter) begin
                    hi_q <= mul_hi;
                    lo_q <= mul_lo;
                end
            end
            if (state_q == ST_DIV) begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                cnt_q <= cnt_q - CW'(1);
            end
            if (state_q == ST_FIX) begin
                hi_q <= div_hi;
                lo_q <= div_lo;
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_DONE);
        hi   = hi_q;
        lo   = lo_q;
    end

    // done is a single-cycle pulse followed by idle
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // Result registers move only into the done cycle
    assert_hilo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi != $past(hi)) || (lo != $past(lo))) |-> done);

    // Partial remainder stays below a nonzero divisor
    assert_rem_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DIV) && (dvs_q != '0)) |=> (rem_q < dvs_q));

    // Multiplier magnitude fully consumed by the chosen step count
    assert_mplier_spent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DONE) && (op_q != OP_DIV)) |-> (mplier_q == '0));

    // No operation restarts out of the done cycle
    assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

endmodule

// File: tb/tb_muldiv_iter.sv
module tb_muldiv_iter;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] K_MULT = 3'd0;
    localparam logic [2:0] K_MUL3 = 3'd1;
    localparam logic [2:0] K_MADD = 3'd2;
    localparam logic [2:0] K_MSUB = 3'd3;
    localparam logic [2:0] K_DIV  = 3'd4;

    logic        clk, rst_n, start, wide, is_signed;
    logic [2:0]  op_sel;
    logic [63:0] opa, opb;
    logic        busy, done;
    logic [63:0] hi, lo;

    int checks;
    int failures;
    logic [63:0] m_hi, m_lo;

    muldiv_iter dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .wide(wide),
        .is_signed(is_signed), .opa(opa), .opb(opb), .busy(busy), .done(done),
        .hi(hi), .lo(lo)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Arithmetic reference model on 128-bit signed values
    task automatic model_step(input logic [2:0] op, input bit w, input bit s,
                              input logic [63:0] a, input logic [63:0] b);
        logic signed [127:0] xa, xb, p, q, r, cat, res;
        if (w) begin
            xa = s ? {{64{a[63]}}, a} : {64'd0, a};
            xb = s ? {{64{b[63]}}, b} : {64'd0, b};
        end else begin
            xa = s ? {{96{a[31]}}, a[31:0]} : {96'd0, a[31:0]};
            xb = s ? {{96{b[31]}}, b[31:0]} : {96'd0, b[31:0]};
        end
        if (op == K_DIV) begin
            q = xa / xb;
            r = xa % xb;
            if (w) begin
                m_hi = r[63:0];
                m_lo = q[63:0];
            end else begin
                m_hi = {{32{r[31]}}, r[31:0]};
                m_lo = {{32{q[31]}}, q[31:0]};
            end
        end else begin
            p   = xa * xb;
            cat = w ? {m_hi, m_lo} : {64'd0, m_hi[31:0], m_lo[31:0]};
            if (op == K_MADD)      res = cat + p;
            else if (op == K_MSUB) res = cat - p;
            else                   res = p;
            if (op != K_MUL3) begin
                m_hi = w ? res[127:64] : {{32{res[63]}}, res[63:32]};
            end
            m_lo = w ? res[63:0] : {{32{res[31]}}, res[31:0]};
        end
    endtask

    task automatic do_op(input logic [2:0] op, input bit w, input bit s,
                         input logic [63:0] a, input logic [63:0] b,
                         input bit vals, input string tag);
        int expn;
        int k;
        logic [63:0] ph, pl;
        bit busy_ok;
        string treq, vreq;
        expn = (op == K_DIV) ? (w ? 66 : 34) : (w ? 9 : 5);
        treq = !vals ? "R9" : ((op == K_DIV) ? "R3" : "R2");
        if (op == K_MUL3)                        vreq = "R6";
        else if (op == K_MADD || op == K_MSUB)   vreq = "R7";
        else if (op == K_DIV)                    vreq = "R8";
        else                                     vreq = "R5";
        ph = m_hi;
        pl = m_lo;
        busy_ok = 1'b1;
        @(negedge clk);
        op_sel = op; wide = w; is_signed = s; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        opa = ~a;          // inputs after acceptance must not matter (R5)
        opb = ~b;
        k = 1;
        while (!done && k < 200) begin
            if (!busy) busy_ok = 1'b0;
            if (k == expn - 1)
                chk((hi == ph) && (lo == pl), "R10", {tag, " hold"}, {hi, lo}, {ph, pl});
            @(negedge clk);
            k++;
        end
        if (!busy) busy_ok = 1'b0;
        chk(k == expn, treq, {tag, " cycles"}, k, expn);
        chk(busy_ok, treq, {tag, " busy"}, busy_ok, 1);
        if (vals) begin
            model_step(op, w, s, a, b);
            chk(hi == m_hi, vreq, {tag, " hi"}, hi, m_hi);
            chk(lo == m_lo, vreq, {tag, " lo"}, lo, m_lo);
        end else begin
            m_hi = hi;
            m_lo = lo;
        end
        @(negedge clk);
        chk(!busy && !done, treq, {tag, " release"}, {busy, done}, 0);
    endtask

    function automatic logic [63:0] corner(input int idx);
        case (idx)
            0: corner = 64'd0;
            1: corner = 64'd1;
            2: corner = 64'hFFFF_FFFF_FFFF_FFFF;
            3: corner = 64'h7FFF_FFFF_FFFF_FFFF;
            4: corner = 64'h8000_0000_0000_0000;
            5: corner = 64'h0123_4567_89AB_CDEF;
            6: corner = 64'hFEDC_BA98_7654_3211;
            default: corner = 64'd7;
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] x, y, ph;
        int k;
        checks = 0; failures = 0;
        m_hi = '0; m_lo = '0;
        rst_n = 1'b0; start = 1'b0; wide = 1'b0; is_signed = 1'b0;
        op_sel = '0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && hi == 0 && lo == 0, "R1", "in reset", {busy, done, hi[61:0], lo}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && hi == 0 && lo == 0, "R1", "after reset", {busy, done, hi[61:0], lo}, 0);

        // Near-exhaustive 32-bit sweep over small signed values, junk in bits 63:32
        for (int i = -8; i < 8; i++) begin
            for (int j = -8; j < 8; j++) begin
                x = {32'hA5A5_0F0F, 32'(i)};
                y = {32'h5A5A_F0F0, 32'(j)};
                do_op(K_MULT, 1'b0, 1'b1, x, y, 1'b1, "mult32s");
                do_op(K_MUL3, 1'b0, 1'b1, y, x, 1'b1, "mul3_32s");
                do_op(K_MADD, 1'b0, 1'b1, x, y, 1'b1, "madd32s");
                do_op(K_MSUB, 1'b0, 1'b0, x, y, 1'b1, "msub32u");
                if (j != 0) begin
                    do_op(K_DIV, 1'b0, 1'b1, x, y, 1'b1, "div32s");
                    do_op(K_DIV, 1'b0, 1'b0, x, y, 1'b1, "div32u");
                end
            end
        end

        // 64-bit corner grid
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                x = corner(i);
                y = corner(j);
                do_op(K_MULT, 1'b1, 1'b1, x, y, 1'b1, "mult64s");
                do_op(K_MADD, 1'b1, 1'b0, x, y, 1'b1, "madd64u");
                do_op(K_MSUB, 1'b1, 1'b1, x, y, 1'b1, "msub64s");
                do_op(K_MUL3, 1'b1, 1'b0, x, y, 1'b1, "mul3_64u");
                if (y != 0) begin
                    do_op(K_DIV, 1'b1, 1'b1, x, y, 1'b1, "div64s");
                    do_op(K_DIV, 1'b1, 1'b0, x, y, 1'b1, "div64u");
                end
            end
        end

        // Pseudo-random 64-bit operands
        x = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 40; n++) begin
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            y = (x >> (n % 50)) | 64'd1;
            do_op(K_MULT, 1'b1, 1'b0, x, y, 1'b1, "mult64u_rnd");
            do_op(K_MADD, 1'b1, 1'b1, y, x, 1'b1, "madd64s_rnd");
            do_op(K_DIV, 1'b1, n[0], x, y, 1'b1, "div64_rnd");
        end

        // Division by zero in both widths (R9)
        do_op(K_DIV, 1'b0, 1'b1, 64'd12345, 64'd0, 1'b0, "div32_by_zero");
        do_op(K_DIV, 1'b1, 1'b0, 64'hDEAD_BEEF, 64'd0, 1'b0, "div64_by_zero");

        // Start while busy and in the done cycle is ignored (R4)
        ph = m_hi;
        @(negedge clk);
        op_sel = K_DIV; wide = 1'b0; is_signed = 1'b1;
        opa = 64'hFFFF_FFFF_FFFF_FF9C; opb = 64'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 200) begin
            if (k == 3) begin
                start = 1'b1; op_sel = K_MULT; wide = 1'b1; opa = 64'd5; opb = 64'd9;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        chk(k == 34, "R4", "div with stray start cycles", k, 34);
        model_step(K_DIV, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7);
        chk(hi == m_hi && lo == m_lo, "R4", "div with stray start result", {hi, lo}, {m_hi, m_lo});
        chk(m_hi != ph, "R4", "model remainder differs", m_hi, ph);
        start = 1'b1; op_sel = K_MULT;
        @(negedge clk);
        chk(!busy, "R4", "start in done cycle ignored", busy, 0);
        start = 1'b0;
        @(negedge clk);
        chk(!busy && hi == m_hi && lo == m_lo, "R4", "idle after ignored start",
            {busy, hi[62:0], lo}, {1'b0, m_hi[62:0], m_lo});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule